// File: doc/BRIEF.md
# Interlocked Four-Phase Bus Master

This block lets a clocked local client run single read or write transfers on a bus that carries no clock. A command holds an address, a direction bit and, for writes, a data word. The master drives these onto the bus. It waits a fixed number of clock cycles so that every slave can decode the address, and then raises its request. The slave's acknowledge is asynchronous, so it passes through a two-stage synchronizer before the controller reacts to it.

The handshake is fully interlocked. The request rises, the acknowledge rises, the request falls, and the acknowledge falls. Only after that last edge does the master report completion and accept a new command. A read captures the slave's data when the controller sees the acknowledge. A write keeps its data driven until that same point. The master never drives the data lines during a read. If no acknowledge arrives within a bounded number of cycles, the master withdraws the request and completes the transfer with an error flag.

Top module: `async4_bus_master`

## Requirements
- R1: While reset is held, and after it is released: bus_req_o, bus_data_oe_o, bus_write_o, rsp_done_o and rsp_err_o are 0, and cmd_ready_o is 1.
- R2: A command is taken at a rising edge where cmd_valid_i and cmd_ready_o are both 1. On that edge bus_addr_o and bus_write_o (1 = write, 0 = read) take the command's values, and cmd_ready_o drops to 0 until the transfer completes.
- R3: bus_req_o rises exactly SETTLE_CYC clock cycles after the command is taken. bus_addr_o and bus_write_o hold their values from acceptance until completion.
- R4: bus_req_o falls on the third rising edge at which bus_ack_i is sampled high, counted from the first such edge (two synchronizer stages plus the controller).
- R5: For a write, bus_data_oe_o is 1 and bus_data_o carries the write data from acceptance until bus_req_o falls. For a read, bus_data_oe_o stays 0, and the value on bus_data_i at the edge where bus_req_o falls is returned on rsp_rdata_o.
- R6: After bus_req_o falls, rsp_done_o goes high on the third rising edge at which bus_ack_i is sampled low. cmd_ready_o returns to 1 on that same edge.
- R7: If the synchronized acknowledge is not seen within TIMEOUT_CYC cycles of the request rising, bus_req_o falls after exactly TIMEOUT_CYC cycles high, and the completion carries rsp_err_o = 1.
- R8: rsp_done_o is a single-cycle pulse. rsp_err_o is 0 on any completion that was acknowledged.
- R9: cmd_valid_i has no effect while a transfer is in progress: no bus output changes because of it.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Local clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cmd_valid_i | input | 1 | Command present |
| cmd_ready_o | output | 1 | Master idle, command can be taken |
| cmd_write_i | input | 1 | 1 = write, 0 = read |
| cmd_addr_i | input | AW | Target address |
| cmd_wdata_i | input | DW | Write data |
| rsp_done_o | output | 1 | One-cycle completion pulse |
| rsp_err_o | output | 1 | Completion ended by timeout |
| rsp_rdata_o | output | DW | Captured read data |
| bus_addr_o | output | AW | Bus address |
| bus_write_o | output | 1 | Bus direction |
| bus_data_o | output | DW | Bus data driven by master |
| bus_data_oe_o | output | 1 | Enables master's data driver |
| bus_data_i | input | DW | Bus data from slave |
| bus_req_o | output | 1 | Handshake request |
| bus_ack_i | input | 1 | Slave acknowledge, asynchronous |

## Verification
A controller stuck in the wrong phase shows up at the ports within one clock. Depending on the fault, the request rises or falls a cycle off its expected edge, a done pulse appears early or is lost, or cmd_ready_o disagrees with the model. A miscounted settle or timeout window moves the request edge by at least one cycle. A wrong synchronizer depth shifts both request fall and done by the same amount. Capture faults in the data path appear as a wrong rsp_rdata_o at the done pulse, or as a wrong value or enable on the data lines while a write is in flight.

// File: rtl/abm_pkg.sv
package abm_pkg;
  typedef enum logic [1:0] {
    ST_IDLE    = 2'd0,
    ST_SETTLE  = 2'd1,
    ST_REQ     = 2'd2,
    ST_RELEASE = 2'd3
  } abm_state_e;
endpackage

// File: rtl/abm_sync.sv
module abm_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic d_i,
  output logic q_o
);
  logic [STAGES-1:0] chain_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) chain_q <= '0;
    else begin
      chain_q[0] <= d_i;
      for (int i = 1; i < STAGES; i++) chain_q[i] <= chain_q[i-1];
    end
  end

  assign q_o = chain_q[STAGES-1];
endmodule

// File: rtl/abm_counter.sv
module abm_counter #(
  parameter int unsigned LIMIT = 4
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic clr_i,
  input  logic en_i,
  output logic hit_o
);
  localparam int unsigned W = $clog2(LIMIT + 1);
  localparam logic [W-1:0] LAST = W'(LIMIT - 1);

  logic [W-1:0] cnt_q;

  assign hit_o = (cnt_q == LAST);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)             cnt_q <= '0;
    else if (clr_i)          cnt_q <= '0;
    else if (en_i && !hit_o) cnt_q <= cnt_q + 1'b1;
  end
endmodule

// File: rtl/async4_bus_master.sv
module async4_bus_master
  import abm_pkg::*;
#(
  parameter int unsigned AW          = 16,
  parameter int unsigned DW          = 16,
  parameter int unsigned SETTLE_CYC  = 3,
  parameter int unsigned TIMEOUT_CYC = 64,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          cmd_valid_i,
  output logic          cmd_ready_o,
  input  logic          cmd_write_i,
  input  logic [AW-1:0] cmd_addr_i,
  input  logic [DW-1:0] cmd_wdata_i,
  output logic          rsp_done_o,
  output logic          rsp_err_o,
  output logic [DW-1:0] rsp_rdata_o,
  output logic [AW-1:0] bus_addr_o,
  output logic          bus_write_o,
  output logic [DW-1:0] bus_data_o,
  output logic          bus_data_oe_o,
  input  logic [DW-1:0] bus_data_i,
  output logic          bus_req_o,
  input  logic          bus_ack_i
);
  abm_state_e state_q, state_d;

  logic          ack_s;
  logic          settle_hit, tmo_hit;
  logic          accept;
  logic [AW-1:0] addr_q;
  logic          wr_q, oe_q, req_q, done_q, err_q;
  logic [DW-1:0] wd_q, rd_q;

  abm_sync #(.STAGES(SYNC_STAGES)) i_ack_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   (bus_ack_i),
    .q_o   (ack_s)
  );

  abm_counter #(.LIMIT(SETTLE_CYC)) i_settle_cnt (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .clr_i (accept),
    .en_i  (state_q == ST_SETTLE),
    .hit_o (settle_hit)
  );

  abm_counter #(.LIMIT(TIMEOUT_CYC)) i_tmo_cnt (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .clr_i (state_q != ST_REQ),
    .en_i  (state_q == ST_REQ),
    .hit_o (tmo_hit)
  );

  assign accept = (state_q == ST_IDLE) && cmd_valid_i;

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_IDLE:    if (cmd_valid_i) state_d = ST_SETTLE;
      ST_SETTLE:  if (settle_hit) state_d = ST_REQ;
      ST_REQ:     if (ack_s || tmo_hit) state_d = ST_RELEASE;
      ST_RELEASE: if (!ack_s) state_d = ST_IDLE;
      default:    state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      addr_q  <= '0;
      wr_q    <= 1'b0;
      wd_q    <= '0;
      oe_q    <= 1'b0;
      req_q   <= 1'b0;
      rd_q    <= '0;
      done_q  <= 1'b0;
      err_q   <= 1'b0;
    end else begin
      state_q <= state_d;
      done_q  <= 1'b0;
      unique case (state_q)
        ST_IDLE: if (cmd_valid_i) begin
          addr_q <= cmd_addr_i;
          wr_q   <= cmd_write_i;
          wd_q   <= cmd_wdata_i;
          oe_q   <= cmd_write_i;
          err_q  <= 1'b0;
        end
        ST_SETTLE: if (settle_hit) req_q <= 1'b1;
        ST_REQ: begin
          if (ack_s) begin
            req_q <= 1'b0;
            oe_q  <= 1'b0;
            if (!wr_q) rd_q <= bus_data_i;
          end else if (tmo_hit) begin
            req_q <= 1'b0;
            oe_q  <= 1'b0;
            err_q <= 1'b1;
          end
        end
        ST_RELEASE: if (!ack_s) done_q <= 1'b1;
        default: ;
      endcase
    end
  end

  assign cmd_ready_o   = (state_q == ST_IDLE);
  assign rsp_done_o    = done_q;
  assign rsp_err_o     = done_q & err_q;
  assign rsp_rdata_o   = rd_q;
  assign bus_addr_o    = addr_q;
  assign bus_write_o   = wr_q;
  assign bus_data_o    = wd_q;
  assign bus_data_oe_o = oe_q;
  assign bus_req_o     = req_q;

  AST_ADDR_HELD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!cmd_ready_o && $past(!cmd_ready_o)) |-> ($stable(bus_addr_o) && $stable(bus_write_o))) // R3
    else $error("address moved during transfer");
  AST_BUSY_NO_ACCEPT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($past(!cmd_ready_o) && !cmd_ready_o) |-> $stable(bus_data_o)) // R9
    else $error("command taken while busy");
  AST_REQ_DROP_CAUSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(bus_req_o) |-> ($past(ack_s) || rsp_err_o || err_q)) // R4
    else $error("request dropped without ack or timeout");
  AST_READ_NO_DRIVE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bus_data_oe_o |-> bus_write_o) // R5
    else $error("data driven during read");
  AST_DONE_AFTER_REQ: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rsp_done_o |-> (!bus_req_o && !ack_s)) // R6
    else $error("done while handshake open");
  AST_DONE_PULSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rsp_done_o |=> !rsp_done_o) // R8
    else $error("done longer than one cycle");
endmodule

// File: tb/test_async4_bus_master.sv
module test_async4_bus_master;
  localparam int AW = 16;
  localparam int DW = 16;
  localparam int SETTLE = 3;
  localparam int TMO = 24;
  localparam logic [DW-1:0] KEY = 16'hA5C3;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #2 clk = ~clk;

  logic          cmd_valid = 1'b0, cmd_write = 1'b0;
  logic [AW-1:0] cmd_addr = '0;
  logic [DW-1:0] cmd_wdata = '0;
  logic          cmd_ready, rsp_done, rsp_err;
  logic [DW-1:0] rsp_rdata, bus_data_o, bus_rdata = '0;
  logic [AW-1:0] bus_addr;
  logic          bus_write, bus_oe, bus_req, bus_ack = 1'b0;

  async4_bus_master #(.AW(AW), .DW(DW), .SETTLE_CYC(SETTLE), .TIMEOUT_CYC(TMO)) i_async4_bus_master (
    .clk_i(clk), .rst_ni(rst_n),
    .cmd_valid_i(cmd_valid), .cmd_ready_o(cmd_ready), .cmd_write_i(cmd_write),
    .cmd_addr_i(cmd_addr), .cmd_wdata_i(cmd_wdata),
    .rsp_done_o(rsp_done), .rsp_err_o(rsp_err), .rsp_rdata_o(rsp_rdata),
    .bus_addr_o(bus_addr), .bus_write_o(bus_write), .bus_data_o(bus_data_o),
    .bus_data_oe_o(bus_oe), .bus_data_i(bus_rdata), .bus_req_o(bus_req), .bus_ack_i(bus_ack)
  );

  int vectors = 0, fails = 0;

  task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
    vectors++;
    if (!ok) begin
      fails++;
      $display("FAIL %s act=%0h exp=%0h t=%0t", tag, act, exp, $time);
    end
  endtask

  // slave model
  int ack_lat = 1, rel_lat = 1, scnt = 0;
  bit no_ack = 0;
  logic [DW-1:0] seen_wdata = '0;
  logic seen_oe = 1'b0;
  always @(negedge clk) if (rst_n) begin
    if (bus_req && !bus_ack) begin
      if (!no_ack) begin
        if (scnt >= ack_lat) begin
          if (bus_write) begin seen_wdata = bus_data_o; seen_oe = bus_oe; end
          else bus_rdata = bus_addr ^ KEY;
          bus_ack = 1'b1; scnt = 0;
        end else scnt++;
      end
    end else if (!bus_req && bus_ack) begin
      if (scnt >= rel_lat) begin bus_ack = 1'b0; scnt = 0; end
      else scnt++;
    end
  end

  // reference model, advanced on every rising edge
  int ph = 0, k = 0;
  bit s1 = 0, s2 = 0;
  bit e_req = 0, e_oe = 0, e_wr = 0, e_done = 0, e_err = 0;
  logic [AW-1:0] e_addr = '0;
  logic [DW-1:0] e_wd = '0, e_rd = '0;
  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ph = 0; k = 0; s1 = 0; s2 = 0; e_req = 0; e_oe = 0; e_wr = 0;
      e_done = 0; e_err = 0; e_addr = '0; e_wd = '0; e_rd = '0;
    end else begin
      e_done = 0;
      case (ph)
        0: if (cmd_valid) begin
             e_addr = cmd_addr; e_wr = cmd_write; e_wd = cmd_wdata;
             e_oe = cmd_write; e_err = 0; k = 0; ph = 1;
           end
        1: if (k == SETTLE-1) begin e_req = 1; k = 0; ph = 2; end else k++;
        2: if (s2) begin
             e_req = 0; e_oe = 0; ph = 3;
             if (!e_wr) e_rd = bus_rdata;
           end else if (k == TMO-1) begin
             e_req = 0; e_oe = 0; e_err = 1; ph = 3;
           end else k++;
        default: if (!s2) begin e_done = 1; ph = 0; end
      endcase
      s2 = s1; s1 = bus_ack;
    end
  end

  // per-cycle compare
  always @(negedge clk) if (rst_n) begin
    chk(cmd_ready === (ph == 0), "R2 ready", cmd_ready, ph == 0);
    chk(bus_req === e_req, "R4 req", bus_req, e_req);
    chk(bus_addr === e_addr, (cmd_valid && ph != 0) ? "R9 addr" : "R3 addr", bus_addr, e_addr);
    chk(bus_write === e_wr, "R2 write", bus_write, e_wr);
    chk(bus_oe === e_oe, "R5 oe", bus_oe, e_oe);
    if (e_oe) chk(bus_data_o === e_wd, "R5 wdata", bus_data_o, e_wd);
    chk(rsp_done === e_done, "R6 done", rsp_done, e_done);
    if (e_done) begin
      chk(rsp_err === e_err, "R7 err", rsp_err, e_err);
      if (!e_wr && !e_err) chk(rsp_rdata === e_rd, "R5 rdata", rsp_rdata, e_rd);
    end
  end

  int cyc = 0;
  always @(posedge clk) begin
    cyc++;
    if (cyc > 100000) begin
      fails++;
      $display("FAIL watchdog expired");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
      $finish;
    end
  end

  task automatic run(input bit wr, input logic [AW-1:0] a, input logic [DW-1:0] d, input bit poke);
    while (!cmd_ready) @(negedge clk);
    cmd_valid = 1'b1; cmd_write = wr; cmd_addr = a; cmd_wdata = d;
    @(negedge clk);
    if (poke) begin
      cmd_addr = ~a; cmd_wdata = ~d; cmd_write = ~wr;
      repeat (2) @(negedge clk);
    end
    cmd_valid = 1'b0;
    while (!rsp_done) @(negedge clk);
    @(negedge clk);
    chk(!rsp_done, "R8 pulse", rsp_done, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk(!bus_req && !bus_oe && !bus_write && !rsp_done && !rsp_err && cmd_ready,
        "R1 reset", {bus_req, bus_oe, bus_write, rsp_done, rsp_err, cmd_ready}, 1);
    rst_n = 1'b1;
    @(negedge clk);
    chk(!bus_req && cmd_ready, "R1 after release", {bus_req, cmd_ready}, 2'b01);

    run(1, 16'h1234, 16'hBEEF, 0);
    chk(seen_wdata === 16'hBEEF && seen_oe, "R5 slave got write", seen_wdata, 16'hBEEF);
    chk(!rsp_err, "R8 no err", rsp_err, 0);
    run(0, 16'h0042, 16'h0, 0);
    chk(rsp_rdata === (16'h0042 ^ KEY), "R5 read value", rsp_rdata, 16'h0042 ^ KEY);

    for (int i = 0; i < 4; i++) begin
      ack_lat = i; rel_lat = 3 - i;
      run(i[0], AW'(16'h0100 + i), DW'(16'h5A00 + i), 1);
    end
    chk(cmd_ready, "R9 idle after busy pokes", cmd_ready, 1);

    ack_lat = 0; rel_lat = 0;
    run(0, 16'hFFFF, 16'h0, 0);
    chk(rsp_rdata === (16'hFFFF ^ KEY), "R5 read fast", rsp_rdata, 16'hFFFF ^ KEY);

    no_ack = 1;
    while (!cmd_ready) @(negedge clk);
    cmd_valid = 1'b1; cmd_write = 1'b0; cmd_addr = 16'h0777;
    @(negedge clk);
    cmd_valid = 1'b0;
    begin
      int hi = 0;
      while (!bus_req) @(negedge clk);
      while (bus_req) begin hi++; @(negedge clk); end
      chk(hi == TMO, "R7 req width", hi, TMO);
      while (!rsp_done) @(negedge clk);
      chk(rsp_err === 1'b1, "R7 err flag", rsp_err, 1);
    end
    no_ack = 0;
    @(negedge clk);
    run(1, 16'h2222, 16'h1357, 0);
    chk(!rsp_err && seen_wdata === 16'h1357, "R8 recovery", seen_wdata, 16'h1357);

    repeat (4) @(negedge clk);
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end
endmodule